// File: doc/BRIEF.md
# 4:2:2 Parallel Video Capture with Frame Structure Checking

This block sits at the input of a video pipeline. Its clock is the incoming pixel clock, nominally 13.5 MHz. Each clock brings one luma sample on an 8-bit bus and one chroma sample on a second 8-bit bus. The chroma samples alternate between the blue and red difference components. A composite blank input is high outside the picture. A vertical sync input marks each new field, and a pulse only one pixel clock wide is enough.

The block pairs up consecutive active samples. Once every two active pixels it emits one 32-bit word with a valid strobe. The word is tagged with its pair position in the line, the active line number within the field, and a field parity bit. While it captures, the block checks the field structure against the selected standard:

| Standard | Active width | Line period (start to start) | Active lines per field |
|---|---|---|---|
| NTSC | 720 | 858 | 240 |
| PAL | 720 | 864 | 288 |

Each kind of mismatch sets its own sticky error flag. The standard-select input is sampled only at a vertical sync edge.

The control is a three-state machine:
- `ST_IDLE`: after reset, waiting for the first sync edge. It moves to `ST_HBLANK` on a sync edge.
- `ST_HBLANK`: inside a field, between active runs. It moves to `ST_ACTIVE` when an active sample arrives.
- `ST_ACTIVE`: inside an active run. It returns to `ST_HBLANK` on the first cycle that is not an active sample.

A sync edge in `ST_HBLANK` or `ST_ACTIVE` leaves or puts the machine in `ST_HBLANK`.

Top module: `vcap_422_rx`

## Requirements
- R1: After reset, `pair_vld_o`, `err_width_o`, `err_lines_o` and `err_period_o` are 0 and `field_o` is 1. Samples are ignored, and no word is emitted, until the first rising edge of `vsync_i`.
- R2: Every rising edge of `vsync_i` is detected, including a pulse one clock wide. Each detected edge toggles `field_o`, which is visible the cycle after the edge.
- R3: The first sample of each active run (blank low) is in the Cb phase. After every second active sample, `pair_vld_o` is high for one cycle, the cycle after that sample. It carries `pair_o` = {Y0 in [31:24], Cb in [23:16], Y1 in [15:8], Cr in [7:0]}, where Y0/Cb is the earlier sample and Y1/Cr the later one.
- R4: `pair_idx_o` counts pairs within the active run, starting at 0. `line_o` counts active runs within the field, starting at 0 after each sync edge.
- R5: Only the first ACTIVE_W samples of a run produce words. Samples beyond that produce no strobe.
- R6: When an active run ends with a length other than ACTIVE_W (720), `err_width_o` is set. It is visible the cycle after the first non-active cycle.
- R7: At each sync edge after the first, `err_lines_o` is set if the number of active runs in the ending field differs from 240 (NTSC) or 288 (PAL). It is visible the cycle after the edge.
- R8: Between two consecutive active-run starts in the same field, the period must equal 858 (NTSC) or 864 (PAL) clocks. Otherwise `err_period_o` is set, visible the cycle after the later start.
- R9: `std_pal_i` (0 = NTSC, 1 = PAL) is sampled only at a sync edge. A change in mid-field has no effect on the checks for that field and applies from the next field.
- R10: The three error flags stay set until reset.
- R11: The cycle that holds a sync edge counts as blanking. Its sample is not captured, and it ends any active run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| std_pal_i | input | 1 | Standard select: 0 = NTSC, 1 = PAL |
| vsync_i | input | 1 | Vertical sync, rising edge marks a new field |
| blank_i | input | 1 | Composite blank, high outside the picture |
| luma_i | input | 8 | Luma sample |
| chroma_i | input | 8 | Chroma sample, Cb and Cr alternating |
| pair_o | output | 32 | Assembled word {Y0, Cb, Y1, Cr} |
| pair_vld_o | output | 1 | One-cycle strobe for `pair_o` |
| pair_idx_o | output | PAIR_W | Pair position within the line |
| line_o | output | LINE_W | Active line number within the field |
| field_o | output | 1 | Field parity, toggles at each sync edge |
| err_width_o | output | 1 | Sticky: active run length wrong |
| err_lines_o | output | 1 | Sticky: active line count wrong |
| err_period_o | output | 1 | Sticky: line period wrong |

## Verification
The bound checker watches several properties on every cycle:
- each error flag stays set once raised;
- strobes are never back to back;
- every strobed word matches the luma and chroma samples of the two cycles before it;
- strobes two cycles apart carry consecutive pair indexes on the same line;
- field parity changes only after sync was high.

Other behaviours depend on whole lines and fields of stimulus, so only the directed scenarios can show them:
- the exact cycle at which each error is raised;
- the deferred effect of a mid-field standard change;
- the suppression of samples past the active width;
- the discarding of a sample that coincides with a sync edge.

The bench runs with reduced line and field sizes so that complete fields fit in a short run.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HBLANK,
        ST_ACTIVE
    } vcap_state_e;

    typedef struct packed {
        logic [7:0] y0;
        logic [7:0] cb;
        logic [7:0] y1;
        logic [7:0] cr;
    } vcap_pair_t;

    function automatic int unsigned vmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vcap_vs_edge.sv
module vcap_vs_edge (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic vsync_i,
    output logic vs_rise_o
);

    logic vs_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) vs_q <= 1'b0;
        else          vs_q <= vsync_i;
    end

    assign vs_rise_o = vsync_i & ~vs_q;

endmodule

// File: rtl/vcap_line_fsm.sv
module vcap_line_fsm
    import vcap_pkg::*;
#(
    parameter int unsigned ACTIVE_W = 720,
    parameter int unsigned RUN_W    = $clog2(ACTIVE_W + 2)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             blank_i,
    input  logic             vs_rise_i,
    output logic             in_field_o,
    output logic             act_o,
    output logic             run_start_o,
    output logic             run_end_o,
    output logic [RUN_W-1:0] samp_idx_o,
    output logic [RUN_W-1:0] run_len_o
);

    localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(ACTIVE_W + 1);

    vcap_state_e      state_q, state_d;
    logic [RUN_W-1:0] run_cnt_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (vs_rise_i) state_d = ST_HBLANK;
            ST_HBLANK: if (act_o)     state_d = ST_ACTIVE;
            ST_ACTIVE: if (!act_o)    state_d = ST_HBLANK;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_field_o  = (state_q != ST_IDLE);
        act_o       = in_field_o && !blank_i && !vs_rise_i;
        run_start_o = act_o && (state_q != ST_ACTIVE);
        run_end_o   = (state_q == ST_ACTIVE) && !act_o;
        samp_idx_o  = run_start_o ? '0 : run_cnt_q;
        run_len_o   = run_cnt_q;
    end

    // sample count within the current run, saturating one past the width
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            run_cnt_q <= '0;
        end else if (act_o) begin
            if (samp_idx_o == RUN_CAP) run_cnt_q <= samp_idx_o;
            else                       run_cnt_q <= samp_idx_o + RUN_W'(1);
        end
    end

endmodule

// File: rtl/vcap_pair_pack.sv
module vcap_pair_pack
    import vcap_pkg::*;
#(
    parameter int unsigned ACTIVE_W = 720,
    parameter int unsigned RUN_W    = $clog2(ACTIVE_W + 2),
    parameter int unsigned PAIR_W   = $clog2(ACTIVE_W / 2),
    parameter int unsigned LINE_W   = 9
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              act_i,
    input  logic [RUN_W-1:0]  samp_idx_i,
    input  logic [7:0]        luma_i,
    input  logic [7:0]        chroma_i,
    input  logic [LINE_W-1:0] line_tag_i,
    output logic [31:0]       pair_o,
    output logic              pair_vld_o,
    output logic [PAIR_W-1:0] pair_idx_o,
    output logic [LINE_W-1:0] line_o
);

    logic       [7:0] y0_q, cb_q;
    vcap_pair_t       word_q;
    logic             emit;
    logic             hold;

    assign hold = act_i && !samp_idx_i[0];
    assign emit = act_i && samp_idx_i[0] && (samp_idx_i < RUN_W'(ACTIVE_W));

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            y0_q <= '0;
            cb_q <= '0;
        end else if (hold) begin
            y0_q <= luma_i;
            cb_q <= chroma_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            word_q     <= '0;
            pair_vld_o <= 1'b0;
            pair_idx_o <= '0;
            line_o     <= '0;
        end else begin
            pair_vld_o <= emit;
            if (emit) begin
                word_q.y0  <= y0_q;
                word_q.cb  <= cb_q;
                word_q.y1  <= luma_i;
                word_q.cr  <= chroma_i;
                pair_idx_o <= PAIR_W'(samp_idx_i >> 1);
                line_o     <= line_tag_i;
            end
        end
    end

    assign pair_o = word_q;

endmodule

// File: rtl/vcap_struct_check.sv
module vcap_struct_check #(
    parameter int unsigned ACTIVE_W   = 720,
    parameter int unsigned NTSC_TOTAL = 858,
    parameter int unsigned PAL_TOTAL  = 864,
    parameter int unsigned NTSC_LINES = 240,
    parameter int unsigned PAL_LINES  = 288,
    parameter int unsigned RUN_W      = 10,
    parameter int unsigned LINE_W     = 9,
    parameter int unsigned PER_W      = 10
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              std_pal_i,
    input  logic              vs_rise_i,
    input  logic              in_field_i,
    input  logic              run_start_i,
    input  logic              run_end_i,
    input  logic [RUN_W-1:0]  run_len_i,
    output logic [LINE_W-1:0] line_tag_o,
    output logic              field_o,
    output logic              err_width_o,
    output logic              err_lines_o,
    output logic              err_period_o
);

    localparam int unsigned MAX_LINES = vcap_pkg::vmax(NTSC_LINES, PAL_LINES);
    localparam int unsigned MAX_TOTAL = vcap_pkg::vmax(NTSC_TOTAL, PAL_TOTAL);
    localparam logic [LINE_W-1:0] LINE_CAP = LINE_W'(MAX_LINES + 1);
    localparam logic [PER_W-1:0]  PER_CAP  = PER_W'(MAX_TOTAL + 1);

    logic              std_q;
    logic [LINE_W-1:0] line_cnt_q;
    logic [PER_W-1:0]  per_cnt_q;
    logic [LINE_W-1:0] exp_lines;
    logic [PER_W-1:0]  exp_total;

    assign exp_lines  = std_q ? LINE_W'(PAL_LINES) : LINE_W'(NTSC_LINES);
    assign exp_total  = std_q ? PER_W'(PAL_TOTAL)  : PER_W'(NTSC_TOTAL);
    assign line_tag_o = line_cnt_q - LINE_W'(1);

    // field bookkeeping: standard latch, line and period counters
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            std_q      <= 1'b0;
            field_o    <= 1'b1;
            line_cnt_q <= '0;
            per_cnt_q  <= '0;
        end else if (vs_rise_i) begin
            std_q      <= std_pal_i;
            field_o    <= ~field_o;
            line_cnt_q <= '0;
            per_cnt_q  <= '0;
        end else if (run_start_i) begin
            per_cnt_q <= PER_W'(1);
            if (line_cnt_q != LINE_CAP) line_cnt_q <= line_cnt_q + LINE_W'(1);
        end else if (in_field_i && per_cnt_q != PER_CAP) begin
            per_cnt_q <= per_cnt_q + PER_W'(1);
        end
    end

    // sticky structure errors
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            err_width_o  <= 1'b0;
            err_lines_o  <= 1'b0;
            err_period_o <= 1'b0;
        end else begin
            if (run_end_i && run_len_i != RUN_W'(ACTIVE_W))
                err_width_o <= 1'b1;
            if (vs_rise_i && in_field_i && line_cnt_q != exp_lines)
                err_lines_o <= 1'b1;
            if (run_start_i && line_cnt_q != '0 && per_cnt_q != exp_total)
                err_period_o <= 1'b1;
        end
    end

endmodule

// File: rtl/vcap_422_rx.sv
module vcap_422_rx #(
    parameter int unsigned ACTIVE_W   = 720,
    parameter int unsigned NTSC_TOTAL = 858,
    parameter int unsigned PAL_TOTAL  = 864,
    parameter int unsigned NTSC_LINES = 240,
    parameter int unsigned PAL_LINES  = 288,
    localparam int unsigned MAX_LINES = vcap_pkg::vmax(NTSC_LINES, PAL_LINES),
    localparam int unsigned MAX_TOTAL = vcap_pkg::vmax(NTSC_TOTAL, PAL_TOTAL),
    localparam int unsigned LINE_W    = $clog2(MAX_LINES + 2),
    localparam int unsigned PAIR_W    = $clog2(ACTIVE_W / 2),
    localparam int unsigned RUN_W     = $clog2(ACTIVE_W + 2),
    localparam int unsigned PER_W     = $clog2(MAX_TOTAL + 2)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              std_pal_i,
    input  logic              vsync_i,
    input  logic              blank_i,
    input  logic [7:0]        luma_i,
    input  logic [7:0]        chroma_i,
    output logic [31:0]       pair_o,
    output logic              pair_vld_o,
    output logic [PAIR_W-1:0] pair_idx_o,
    output logic [LINE_W-1:0] line_o,
    output logic              field_o,
    output logic              err_width_o,
    output logic              err_lines_o,
    output logic              err_period_o
);

    logic              vs_rise;
    logic              in_field, act, run_start, run_end;
    logic [RUN_W-1:0]  samp_idx, run_len;
    logic [LINE_W-1:0] line_tag;

    vcap_vs_edge u_vs (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .vsync_i   (vsync_i),
        .vs_rise_o (vs_rise)
    );

    vcap_line_fsm #(
        .ACTIVE_W (ACTIVE_W),
        .RUN_W    (RUN_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .blank_i     (blank_i),
        .vs_rise_i   (vs_rise),
        .in_field_o  (in_field),
        .act_o       (act),
        .run_start_o (run_start),
        .run_end_o   (run_end),
        .samp_idx_o  (samp_idx),
        .run_len_o   (run_len)
    );

    vcap_pair_pack #(
        .ACTIVE_W (ACTIVE_W),
        .RUN_W    (RUN_W),
        .PAIR_W   (PAIR_W),
        .LINE_W   (LINE_W)
    ) u_pack (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .act_i      (act),
        .samp_idx_i (samp_idx),
        .luma_i     (luma_i),
        .chroma_i   (chroma_i),
        .line_tag_i (line_tag),
        .pair_o     (pair_o),
        .pair_vld_o (pair_vld_o),
        .pair_idx_o (pair_idx_o),
        .line_o     (line_o)
    );

    vcap_struct_check #(
        .ACTIVE_W   (ACTIVE_W),
        .NTSC_TOTAL (NTSC_TOTAL),
        .PAL_TOTAL  (PAL_TOTAL),
        .NTSC_LINES (NTSC_LINES),
        .PAL_LINES  (PAL_LINES),
        .RUN_W      (RUN_W),
        .LINE_W     (LINE_W),
        .PER_W      (PER_W)
    ) u_chk (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .std_pal_i    (std_pal_i),
        .vs_rise_i    (vs_rise),
        .in_field_i   (in_field),
        .run_start_i  (run_start),
        .run_end_i    (run_end),
        .run_len_i    (run_len),
        .line_tag_o   (line_tag),
        .field_o      (field_o),
        .err_width_o  (err_width_o),
        .err_lines_o  (err_lines_o),
        .err_period_o (err_period_o)
    );

endmodule

// File: rtl/vcap_422_rx_chk.sv
module vcap_422_rx_chk #(
    parameter int unsigned PAIR_W = 9,
    parameter int unsigned LINE_W = 9
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              vsync_i,
    input logic              blank_i,
    input logic [7:0]        luma_i,
    input logic [7:0]        chroma_i,
    input logic [31:0]       pair_o,
    input logic              pair_vld_o,
    input logic [PAIR_W-1:0] pair_idx_o,
    input logic [LINE_W-1:0] line_o,
    input logic              field_o,
    input logic              err_width_o,
    input logic              err_lines_o,
    input logic              err_period_o
);

    p_err_width_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        err_width_o |=> err_width_o);

    p_err_lines_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        err_lines_o |=> err_lines_o);

    p_err_period_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        err_period_o |=> err_period_o);

    p_vld_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pair_vld_o |=> !pair_vld_o);

    p_vld_from_active_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pair_vld_o |-> !$past(blank_i));

    p_word_layout_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pair_vld_o |-> (pair_o[15:8]  == $past(luma_i))    &&
                       (pair_o[7:0]   == $past(chroma_i))  &&
                       (pair_o[31:24] == $past(luma_i, 2)) &&
                       (pair_o[23:16] == $past(chroma_i, 2)));

    p_pair_step_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (pair_vld_o && $past(pair_vld_o, 2)) |->
            (pair_idx_o == $past(pair_idx_o, 2) + PAIR_W'(1)) && (line_o == $past(line_o, 2)));

    p_field_on_vsync_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(field_o) |-> $past(vsync_i));

endmodule

bind vcap_422_rx vcap_422_rx_chk #(
    .PAIR_W (PAIR_W),
    .LINE_W (LINE_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .vsync_i      (vsync_i),
    .blank_i      (blank_i),
    .luma_i       (luma_i),
    .chroma_i     (chroma_i),
    .pair_o       (pair_o),
    .pair_vld_o   (pair_vld_o),
    .pair_idx_o   (pair_idx_o),
    .line_o       (line_o),
    .field_o      (field_o),
    .err_width_o  (err_width_o),
    .err_lines_o  (err_lines_o),
    .err_period_o (err_period_o)
);

// File: tb/vcap_422_rx_tb_top.sv
module vcap_422_rx_tb_top;

    localparam int unsigned ACT   = 8;
    localparam int unsigned NT_T  = 12;
    localparam int unsigned PAL_T = 14;
    localparam int unsigned NT_L  = 3;
    localparam int unsigned PAL_L = 4;
    localparam int unsigned LW    = $clog2(PAL_L + 2);
    localparam int unsigned PW    = $clog2(ACT / 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          std_pal = 1'b0;
    logic          vsync = 1'b0;
    logic          blank = 1'b1;
    logic [7:0]    luma = '0;
    logic [7:0]    chroma = '0;
    logic [31:0]   pair;
    logic          pair_vld;
    logic [PW-1:0] pair_idx;
    logic [LW-1:0] line;
    logic          field;
    logic          err_w, err_l, err_p;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    vcap_422_rx #(
        .ACTIVE_W   (ACT),
        .NTSC_TOTAL (NT_T),
        .PAL_TOTAL  (PAL_T),
        .NTSC_LINES (NT_L),
        .PAL_LINES  (PAL_L)
    ) dut_i (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .std_pal_i    (std_pal),
        .vsync_i      (vsync),
        .blank_i      (blank),
        .luma_i       (luma),
        .chroma_i     (chroma),
        .pair_o       (pair),
        .pair_vld_o   (pair_vld),
        .pair_idx_o   (pair_idx),
        .line_o       (line),
        .field_o      (field),
        .err_width_o  (err_w),
        .err_lines_o  (err_l),
        .err_period_o (err_p)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one sample, then wait until just after the edge that consumes it
    task automatic step(input logic b, input logic v, input logic [7:0] y, input logic [7:0] c);
        blank  = b;
        vsync  = v;
        luma   = y;
        chroma = c;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic vs_pulse();
        step(1'b1, 1'b1, 8'h00, 8'h00);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        std_pal = 1'b0;
        step(1'b1, 1'b0, 8'h00, 8'h00);
        step(1'b1, 1'b0, 8'h00, 8'h00);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 8'h00, 8'h00);
    endtask

    function automatic logic [7:0] cval(input logic [7:0] base, input int i);
        return 8'(base + 8'h40 + 8'(i * 3));
    endfunction

    // one active run of n samples followed by blanking up to total clocks
    task automatic send_line(input int n, input int total, input logic [7:0] base, input int ln);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, 8'(base + 8'(i)), cval(base, i));
            if (i % 2 == 1 && i < int'(ACT)) begin
                check("R3 strobe", {31'd0, pair_vld}, 32'd1);
                check("R3 word", pair,
                      {8'(base + 8'(i - 1)), cval(base, i - 1), 8'(base + 8'(i)), cval(base, i)});
                check("R4 pair index", {{(32-PW){1'b0}}, pair_idx}, 32'(i / 2));
                check("R4 line tag", {{(32-LW){1'b0}}, line}, 32'(ln));
            end else begin
                check("R3/R5 no strobe", {31'd0, pair_vld}, 32'd0);
            end
        end
        idle(total - n);
    endtask

    task automatic errs_are(input string tag, input logic w, input logic l, input logic p);
        check({tag, " width"},  {31'd0, err_w}, {31'd0, w});
        check({tag, " lines"},  {31'd0, err_l}, {31'd0, l});
        check({tag, " period"}, {31'd0, err_p}, {31'd0, p});
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 vld after reset", {31'd0, pair_vld}, 32'd0);
        check("R1 field after reset", {31'd0, field}, 32'd1);
        errs_are("R1 reset", 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0, 8'(i), 8'(i));
            check("R1 ignored before sync", {31'd0, pair_vld}, 32'd0);
        end
        idle(3);
    endtask

    task automatic t_ntsc_field();
        std_pal = 1'b0;
        vs_pulse();
        check("R2 field toggles on one-cycle pulse", {31'd0, field}, 32'd0);
        idle(2);
        for (int ln = 0; ln < int'(NT_L); ln++) send_line(ACT, NT_T, 8'(16 * ln + 1), ln);
        std_pal = 1'b1;
        vs_pulse();
        check("R2 field toggles again", {31'd0, field}, 32'd1);
        errs_are("R6 R7 R8 clean NTSC field", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_pal_field();
        idle(1);
        for (int ln = 0; ln < int'(PAL_L); ln++) send_line(ACT, PAL_T, 8'(16 * ln + 7), ln);
        vs_pulse();
        errs_are("R7 R8 clean PAL field", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_mode_midfield();
        idle(1);
        send_line(ACT, PAL_T, 8'h21, 0);
        std_pal = 1'b0;
        for (int ln = 1; ln < int'(PAL_L); ln++) send_line(ACT, PAL_T, 8'h31, ln);
        vs_pulse();
        errs_are("R9 mid-field change ignored", 1'b0, 1'b0, 1'b0);
        idle(1);
        for (int ln = 0; ln < int'(NT_L); ln++) send_line(ACT, NT_T, 8'h51, ln);
        vs_pulse();
        errs_are("R9 new standard from next field", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_overlong_run();
        do_reset();
        vs_pulse();
        idle(1);
        send_line(ACT + 2, NT_T, 8'h60, 0);
        check("R5 R6 width error after long run", {31'd0, err_w}, 32'd1);
        send_line(ACT, NT_T, 8'h70, 1);
        send_line(ACT, NT_T, 8'h78, 2);
        vs_pulse();
        check("R10 width error stays set", {31'd0, err_w}, 32'd1);
        check("R7 line count fine", {31'd0, err_l}, 32'd0);
    endtask

    task automatic t_short_run();
        do_reset();
        vs_pulse();
        idle(1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 8'(i), 8'(i));
        check("R6 no width error inside run", {31'd0, err_w}, 32'd0);
        step(1'b1, 1'b0, 8'h00, 8'h00);
        check("R6 width error after short run", {31'd0, err_w}, 32'd1);
        idle(4);
    endtask

    task automatic t_line_count();
        do_reset();
        vs_pulse();
        idle(1);
        send_line(ACT, NT_T, 8'h10, 0);
        send_line(ACT, NT_T, 8'h20, 1);
        check("R7 no line error before sync", {31'd0, err_l}, 32'd0);
        vs_pulse();
        errs_are("R7 short field", 1'b0, 1'b1, 1'b0);
        idle(3);
        check("R10 line error stays set", {31'd0, err_l}, 32'd1);
    endtask

    task automatic t_period();
        do_reset();
        vs_pulse();
        idle(1);
        send_line(ACT, NT_T + 1, 8'h10, 0);
        check("R8 no period error yet", {31'd0, err_p}, 32'd0);
        step(1'b0, 1'b0, 8'h01, 8'h02);
        check("R8 period error at next start", {31'd0, err_p}, 32'd1);
        idle(4);
    endtask

    task automatic t_sync_in_run();
        do_reset();
        vs_pulse();
        idle(1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'(i), 8'(i));
        step(1'b0, 1'b1, 8'hAA, 8'hBB);
        check("R11 sync cycle not captured", {31'd0, pair_vld}, 32'd0);
        check("R11 sync ends run", {31'd0, err_w}, 32'd1);
        check("R2 field toggled", {31'd0, field}, 32'd1);
        idle(3);
    endtask

    task automatic run_all();
        t_reset_state();
        t_ntsc_field();
        t_pal_field();
        t_mode_midfield();
        t_overlong_run();
        t_short_run();
        t_line_count();
        t_period();
        t_sync_in_run();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule